// File: doc/BRIEF.md
# Quarter-Warp Dual-Issue Sequencer

This block sits after the warp issue stage. It takes one warp instruction at a time and runs it across an 8-lane SIMD group in quarter-warp slices. A 32-thread warp is covered in four consecutive fast cycles, with eight threads per cycle. Two groups run side by side: one for multiply-add work (MAD) and one for special-function and multiply work (SFU). Each group has its own slice counter. Arithmetic and operand fetch happen elsewhere. This block only says which threads each lane holds in each fast cycle, and for which warp.

The design uses a single clock, which is the fast (ALU) clock. An internal phase counter marks the start of each slow (front-end) cycle, and one slow cycle equals two fast cycles. New work can be taken only on a slow-cycle start, and only if the targeted group is idle or is in its last quarter. The issue interface is valid/ready and behaves as follows:
- `issue_ready` is combinational on `issue_type` and may drop while `issue_valid` is held.
- The instruction is taken on any rising edge where both are high.
- The issuer must hold `issue_type` and `issue_warp` stable until that edge.

As a result, when MAD and SFU instructions alternate, one instruction can start every slow cycle. Two instructions of the same type can start at best every second slow cycle.

Top module: `qwds_seq`

## Requirements
- R1: While `rst_n` is low, `issue_ready`, `mad_active` and `sfu_active` are all low.
- R2: `slow_edge` is high in the first cycle after reset is released and then toggles every clock cycle.
- R3: `issue_ready` is high only in cycles where `slow_edge` is high and the group selected by `issue_type` is either idle or showing quarter 3.
- R4: When an instruction is accepted (`issue_valid` and `issue_ready` high at a rising edge), its group shows quarters 0, 1, 2 and 3 on the next four cycles and then goes idle unless it is given new work.
- R5: While a group is active in quarter k, all 8 lane enables are high and lane l reports thread index 8k+l (5 bits, field l of the packed bus at bits [5l+4:5l]). While the group is idle, its enables and thread indices are zero.
- R6: A group reports the warp id of the accepted instruction, unchanged, through all four of its quarters.
- R7: `issue_type` 0 selects the MAD group and 1 selects the SFU group. The other group is not touched.
- R8: An instruction of the other type can be accepted one slow cycle after the first. The two groups then run at the same time, giving 16 lane operations per fast cycle.
- R9: A second instruction of the same type is held off until the first one's quarter 3. It is then accepted so that its quarter 0 comes right after that quarter 3, with no gap.
- R10: An instruction held off by a busy group does not change the warp, quarter or threads of the work that group is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue stage offers an instruction |
| issue_type | input | 1 | 0 = MAD group, 1 = SFU group |
| issue_warp | input | 5 | Warp id of the offered instruction |
| issue_ready | output | 1 | Instruction taken at the next rising edge if valid |
| slow_edge | output | 1 | High in the first fast cycle of each slow cycle |
| mad_active | output | 1 | MAD group is running a quarter |
| mad_quarter | output | 2 | Quarter index of the MAD group |
| mad_warp | output | 5 | Warp id on the MAD group |
| mad_lane_en | output | 8 | Per-lane enable of the MAD group |
| mad_tid | output | 40 | Packed 5-bit thread index per MAD lane |
| sfu_active | output | 1 | SFU group is running a quarter |
| sfu_quarter | output | 2 | Quarter index of the SFU group |
| sfu_warp | output | 5 | Warp id on the SFU group |
| sfu_lane_en | output | 8 | Per-lane enable of the SFU group |
| sfu_tid | output | 40 | Packed 5-bit thread index per SFU lane |

## Verification
The assertions assume that the issue stage keeps `issue_type` and `issue_warp` stable while `issue_valid` is high and not yet accepted. They also assume that `issue_type` is never unknown. The quarter-progression properties rely on acceptance happening only at a slow-cycle start. The stimulus drives every input on the falling edge and holds it until the acceptance edge, so the properties see clean values. The directed scenarios begin both from idle groups and from groups in the middle of a quarter, which covers each acceptance timing the properties describe.

// File: rtl/qwds_pkg.sv
package qwds_pkg;
  typedef enum logic {
    GRP_MAD = 1'b0,
    GRP_SFU = 1'b1
  } grp_e;

  localparam int unsigned NUM_GRP = 2;
endpackage

// File: rtl/qwds_phase.sv
module qwds_phase #(
  parameter int unsigned SLOW_RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_edge
);
  localparam int unsigned PH_W = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOW_RATIO - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign slow_edge = (ph_q == '0);
endmodule

// File: rtl/qwds_group.sv
module qwds_group #(
  parameter int unsigned WARP_SIZE = 32,
  parameter int unsigned LANES     = 8,
  parameter int unsigned WARP_W    = 5,
  localparam int unsigned QUARTERS = WARP_SIZE / LANES,
  localparam int unsigned Q_W      = (QUARTERS > 1) ? $clog2(QUARTERS) : 1,
  localparam int unsigned TID_W    = (WARP_SIZE > 1) ? $clog2(WARP_SIZE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [WARP_W-1:0]      start_warp,
  output logic                   avail,
  output logic                   active,
  output logic [Q_W-1:0]         quarter,
  output logic [WARP_W-1:0]      warp,
  output logic [LANES-1:0]       lane_en,
  output logic [LANES*TID_W-1:0] tid
);
  localparam logic [Q_W-1:0] Q_LAST = Q_W'(QUARTERS - 1);

  logic              busy_q;
  logic [Q_W-1:0]    qtr_q;
  logic [WARP_W-1:0] warp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      qtr_q  <= '0;
      warp_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      qtr_q  <= '0;
      warp_q <= start_warp;
    end else if (busy_q) begin
      if (qtr_q == Q_LAST) begin
        busy_q <= 1'b0;
        qtr_q  <= '0;
      end else begin
        qtr_q <= qtr_q + 1'b1;
      end
    end
  end

  // Free for new work when idle, or in the slice that finishes this cycle.
  assign avail   = !busy_q || (qtr_q == Q_LAST);
  assign active  = busy_q;
  assign quarter = qtr_q;
  assign warp    = warp_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = busy_q;
    assign tid[l*TID_W +: TID_W] =
      busy_q ? TID_W'(int'(qtr_q) * LANES + l) : '0;
  end
endmodule

// File: rtl/qwds_issue_gate.sv
module qwds_issue_gate
  import qwds_pkg::*;
(
  input  logic               rst_n,
  input  logic               slow_edge,
  input  logic               in_valid,
  input  grp_e               in_type,
  input  logic [NUM_GRP-1:0] grp_avail,
  output logic               in_ready,
  output logic [NUM_GRP-1:0] grp_start
);
  assign in_ready = rst_n && slow_edge && grp_avail[in_type];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_start
    assign grp_start[g] = in_valid && in_ready && (int'(in_type) == g);
  end
endmodule

// File: rtl/qwds_seq.sv
module qwds_seq
  import qwds_pkg::*;
#(
  parameter int unsigned WARP_SIZE  = 32,
  parameter int unsigned LANES      = 8,
  parameter int unsigned WARP_W     = 5,
  parameter int unsigned SLOW_RATIO = 2,
  localparam int unsigned QUARTERS  = WARP_SIZE / LANES,
  localparam int unsigned Q_W       = (QUARTERS > 1) ? $clog2(QUARTERS) : 1,
  localparam int unsigned TID_W     = (WARP_SIZE > 1) ? $clog2(WARP_SIZE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_valid,
  input  logic                   issue_type,
  input  logic [WARP_W-1:0]      issue_warp,
  output logic                   issue_ready,
  output logic                   slow_edge,
  output logic                   mad_active,
  output logic [Q_W-1:0]         mad_quarter,
  output logic [WARP_W-1:0]      mad_warp,
  output logic [LANES-1:0]       mad_lane_en,
  output logic [LANES*TID_W-1:0] mad_tid,
  output logic                   sfu_active,
  output logic [Q_W-1:0]         sfu_quarter,
  output logic [WARP_W-1:0]      sfu_warp,
  output logic [LANES-1:0]       sfu_lane_en,
  output logic [LANES*TID_W-1:0] sfu_tid
);
  logic [NUM_GRP-1:0]     g_avail;
  logic [NUM_GRP-1:0]     g_start;
  logic [NUM_GRP-1:0]     g_active;
  logic [Q_W-1:0]         g_qtr   [NUM_GRP];
  logic [WARP_W-1:0]      g_warp  [NUM_GRP];
  logic [LANES-1:0]       g_en    [NUM_GRP];
  logic [LANES*TID_W-1:0] g_tid   [NUM_GRP];

  qwds_phase #(.SLOW_RATIO(SLOW_RATIO)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_edge (slow_edge)
  );

  qwds_issue_gate u_gate (
    .rst_n     (rst_n),
    .slow_edge (slow_edge),
    .in_valid  (issue_valid),
    .in_type   (grp_e'(issue_type)),
    .grp_avail (g_avail),
    .in_ready  (issue_ready),
    .grp_start (g_start)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    qwds_group #(
      .WARP_SIZE (WARP_SIZE),
      .LANES     (LANES),
      .WARP_W    (WARP_W)
    ) u_group (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (g_start[g]),
      .start_warp (issue_warp),
      .avail      (g_avail[g]),
      .active     (g_active[g]),
      .quarter    (g_qtr[g]),
      .warp       (g_warp[g]),
      .lane_en    (g_en[g]),
      .tid        (g_tid[g])
    );
  end

  assign mad_active  = g_active[GRP_MAD];
  assign mad_quarter = g_qtr[GRP_MAD];
  assign mad_warp    = g_warp[GRP_MAD];
  assign mad_lane_en = g_en[GRP_MAD];
  assign mad_tid     = g_tid[GRP_MAD];
  assign sfu_active  = g_active[GRP_SFU];
  assign sfu_quarter = g_qtr[GRP_SFU];
  assign sfu_warp    = g_warp[GRP_SFU];
  assign sfu_lane_en = g_en[GRP_SFU];
  assign sfu_tid     = g_tid[GRP_SFU];
endmodule

// File: rtl/qwds_seq_chk.sv
module qwds_seq_chk #(
  parameter int unsigned Q_W    = 2,
  parameter int unsigned WARP_W = 5,
  parameter int unsigned LANES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_type,
  input logic              issue_ready,
  input logic              slow_edge,
  input logic              mad_active,
  input logic [Q_W-1:0]    mad_quarter,
  input logic [WARP_W-1:0] mad_warp,
  input logic [LANES-1:0]  mad_lane_en,
  input logic              sfu_active,
  input logic [Q_W-1:0]    sfu_quarter,
  input logic [WARP_W-1:0] sfu_warp
);
  localparam logic [Q_W-1:0] Q_LAST = '1;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!issue_ready && !mad_active && !sfu_active);
    end
  end

  assert_phase_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_edge |=> !slow_edge);

  assert_ready_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ready |-> slow_edge);

  assert_mad_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mad_active && mad_quarter != Q_LAST && !issue_type) |-> !issue_ready);

  assert_mad_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !issue_type) |=> (mad_active && mad_quarter == '0));

  assert_sfu_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && issue_type) |=> (sfu_active && sfu_quarter == '0));

  assert_mad_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mad_active && mad_quarter != Q_LAST) |=>
      (mad_active && mad_quarter == $past(mad_quarter) + 1'b1));

  assert_mad_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mad_active |-> ($countones(mad_lane_en) == LANES));

  assert_mad_warp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mad_active && mad_quarter != Q_LAST) |=> $stable(mad_warp));

  assert_sfu_warp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfu_active && sfu_quarter != Q_LAST) |=> $stable(sfu_warp));
endmodule

bind qwds_seq qwds_seq_chk #(
  .Q_W    (Q_W),
  .WARP_W (WARP_W),
  .LANES  (LANES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_type  (issue_type),
  .issue_ready (issue_ready),
  .slow_edge   (slow_edge),
  .mad_active  (mad_active),
  .mad_quarter (mad_quarter),
  .mad_warp    (mad_warp),
  .mad_lane_en (mad_lane_en),
  .sfu_active  (sfu_active),
  .sfu_quarter (sfu_quarter),
  .sfu_warp    (sfu_warp)
);

// File: tb/qwds_seq_bench.sv
module qwds_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_type = 1'b0;
  logic [4:0]  issue_warp = '0;
  logic        issue_ready, slow_edge;
  logic        mad_active, sfu_active;
  logic [1:0]  mad_quarter, sfu_quarter;
  logic [4:0]  mad_warp, sfu_warp;
  logic [7:0]  mad_lane_en, sfu_lane_en;
  logic [39:0] mad_tid, sfu_tid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  qwds_seq u_qwds_seq (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_type(issue_type), .issue_warp(issue_warp),
    .issue_ready(issue_ready), .slow_edge(slow_edge),
    .mad_active(mad_active), .mad_quarter(mad_quarter), .mad_warp(mad_warp),
    .mad_lane_en(mad_lane_en), .mad_tid(mad_tid),
    .sfu_active(sfu_active), .sfu_quarter(sfu_quarter), .sfu_warp(sfu_warp),
    .sfu_lane_en(sfu_lane_en), .sfu_tid(sfu_tid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Check one group's visible state: grp 0 MAD, 1 SFU; q<0 means idle.
  task automatic check_grp(input string req, input int grp, input int q, input int w);
    logic act; logic [1:0] qt; logic [4:0] wp; logic [7:0] en; logic [39:0] td;
    act = grp == 0 ? mad_active  : sfu_active;
    qt  = grp == 0 ? mad_quarter : sfu_quarter;
    wp  = grp == 0 ? mad_warp    : sfu_warp;
    en  = grp == 0 ? mad_lane_en : sfu_lane_en;
    td  = grp == 0 ? mad_tid     : sfu_tid;
    if (q < 0) begin
      check(req, "idle active", int'(act), 0);
      check(req, "idle lane_en", int'(en), 0);
      check(req, "idle tid", (td == '0) ? 0 : 1, 0);
    end else begin
      check(req, "active", int'(act), 1);
      check(req, "quarter", int'(qt), q);
      check(req, "warp", int'(wp), w);
      check("R5", "lane_en", int'(en), 255);
      for (int l = 0; l < 8; l++) begin
        check("R5", "tid", int'(td[l*5 +: 5]), q * 8 + l);
      end
    end
  endtask

  // Offer an instruction; return number of falling edges waited for ready.
  task automatic send(input logic t, input logic [4:0] w, output int waits);
    waits = 0;
    issue_valid = 1'b1; issue_type = t; issue_warp = w;
    #1;
    while (!issue_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    issue_valid = 1'b1; issue_type = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "ready in reset", int'(issue_ready), 0);
    check("R1", "mad in reset", int'(mad_active), 0);
    check("R1", "sfu in reset", int'(sfu_active), 0);
    issue_valid = 1'b0;
    rst_n = 1'b1;
    #1;
    check("R2", "slow_edge first", int'(slow_edge), 1);
    check_grp("R5", 0, -1, 0);
    @(negedge clk); #1;
    check("R2", "slow_edge second", int'(slow_edge), 0);
    issue_valid = 1'b1; issue_type = 1'b0;
    #1;
    check("R3", "ready off edge", int'(issue_ready), 0);
    issue_valid = 1'b0;
    @(negedge clk); #1;
    check("R2", "slow_edge third", int'(slow_edge), 1);
  endtask

  task automatic t_single(input logic t, input logic [4:0] w);
    int waits;
    int g;
    g = int'(t);
    send(t, w, waits);
    for (int q = 0; q < 4; q++) begin
      check_grp("R4", g, q, int'(w));
      check_grp("R7", 1 - g, -1, 0);
      @(negedge clk); #1;
    end
    check_grp("R4", g, -1, 0);
    @(negedge clk); #1;
  endtask

  task automatic t_alternate();
    int waits;
    send(1'b0, 5'd3, waits);
    check_grp("R4", 0, 0, 3);
    send(1'b1, 5'd9, waits);
    check("R8", "sfu waits", waits, 1);
    check_grp("R8", 0, 2, 3);
    check_grp("R8", 1, 0, 9);
    check("R8", "lanes busy", $countones({mad_lane_en, sfu_lane_en}), 16);
    @(negedge clk); #1;
    check_grp("R8", 0, 3, 3);
    check_grp("R8", 1, 1, 9);
    @(negedge clk); #1;
    check_grp("R8", 0, -1, 0);
    check_grp("R8", 1, 2, 9);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic t_same_type();
    int waits;
    send(1'b0, 5'd7, waits);
    issue_valid = 1'b1; issue_type = 1'b0; issue_warp = 5'd8;
    for (int q = 0; q < 3; q++) begin
      #1;
      check("R9", "held ready", int'(issue_ready), 0);
      check_grp("R10", 0, q, 7);
      @(negedge clk);
    end
    #1;
    check("R9", "ready at q3", int'(issue_ready), 1);
    check_grp("R10", 0, 3, 7);
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    #1;
    check_grp("R9", 0, 0, 8);
    repeat (4) @(negedge clk);
    #1;
    check_grp("R4", 0, -1, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single(1'b0, 5'd5);
    t_single(1'b1, 5'd17);
    t_alternate();
    t_same_type();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule